// File: doc/BRIEF.md
# Step-Pulse Trim Sequencer

This block sits in a host-side FPGA and drives a trim potentiometer that is adjusted over three wires: an active-low select, a direction level and an active-low step line. A falling step edge moves the device's wiper by one tap while it is selected. The host hands over one command through a valid/ready handshake. The command carries a step count, a direction and a commit flag. The sequencer then plays out the waveform with every minimum setup, pulse-width, hold and recovery time met. Each time is converted to clock cycles from a clock-frequency parameter by rounding up.

How a command ends depends on the commit flag. With commit set, select is released while the step line is HIGH, which makes the device save its position to nonvolatile storage. With commit clear, the low phase of the last step is held through the release, so nothing is saved. The step line is raised only once the device is deselected. After every release, select stays HIGH for a long recovery time before the next command is taken. The sequencer also keeps a shadow of the expected wiper position, which saturates at both ends of the tap range.

Top module: `trim_seq`

## Requirements
- R1: After reset, sel_n and step_n are 1, busy and done are 0, cmd_ready is 1 and wiper_pos equals RESET_POS (0 by default).
- R2: cmd_ready is 1 only when the sequencer is idle and the deselect recovery has expired. A command is taken on a clock edge where cmd_valid and cmd_ready are both 1.
- R3: dir_up takes the value of cmd_up (1 means up) when a command is taken and holds it while sel_n is 0. sel_n stays 0 with step_n at 1 for at least the larger of the select setup and direction setup counts (363 cycles at 125 MHz) before the first falling edge of step_n.
- R4: A command with N steps makes exactly N falling edges on step_n, all while sel_n is 0. Each low phase lasts at least 125 cycles. Each high phase between two steps lasts at least 125 cycles at 125 MHz.
- R5: With cmd_commit = 1, step_n is 1 at the edge where sel_n rises, and it has been 1 for at least the tail count (125 cycles) before that edge.
- R6: With cmd_commit = 0 and N > 0, step_n is 0 at the edge where sel_n rises. The last low phase lasts at least the larger of the low-width and tail counts. step_n returns to 1 only after sel_n is 1.
- R7: A command with zero steps and cmd_commit = 0 does not touch sel_n or step_n. It produces a done pulse and starts no recovery. A command with zero steps and cmd_commit = 1 selects the device and releases it with step_n at 1.
- R8: After any rise of sel_n, sel_n stays 1 for at least the recovery count before it falls again. The default is 20 ms, converted to cycles.
- R9: wiper_pos changes only on a falling edge of step_n. It moves by +1 when dir_up is 1 and by -1 when dir_up is 0, holds at 31 going up and at 0 going down, and never wraps.
- R10: busy is 1 from the cycle after a command is taken until the sequencer is idle again. done is a single-cycle pulse, issued in the cycle the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | A command can be taken |
| cmd_steps | input | STEP_W | Number of steps to issue |
| cmd_up | input | 1 | Direction, 1 = up, 0 = down |
| cmd_commit | input | 1 | 1 = save the position on release |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| sel_n | output | 1 | Device select, active low |
| dir_up | output | 1 | Direction line to the device |
| step_n | output | 1 | Step line, active on its falling edge |
| wiper_pos | output | POS_W | Shadow of the expected wiper tap |

## Verification
The assertions take for granted that rst_n is held long enough to clear the sequencer. They also assume that cmd_steps, cmd_up and cmd_commit are steady while cmd_valid waits for cmd_ready. Every waveform property is then a consequence of the block's own timers. The stimulus raises cmd_valid on a falling clock edge and holds the command fields until the edge where cmd_ready is seen. It overrides the recovery time with a shorter one so that several back-to-back commands fit in a run. It drives the shadow into both saturation limits with step counts that exceed the remaining headroom.

// File: rtl/trim_seq.sv
module trim_seq #(
  parameter longint CLK_HZ         = 125_000_000,
  parameter int     STEP_W         = 6,
  parameter int     POS_W          = 5,
  parameter int     RESET_POS      = 0,
  parameter longint T_SEL_SETUP_NS = 100,
  parameter longint T_DIR_SETUP_NS = 2900,
  parameter longint T_DIR_HOLD_NS  = 100,
  parameter longint T_LOW_NS       = 1000,
  parameter longint T_HIGH_NS      = 1000,
  parameter longint T_TAIL_NS      = 1000,
  parameter longint T_RECOV_NS     = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_up,
  input  logic              cmd_commit,
  output logic              busy,
  output logic              done,
  output logic              sel_n,
  output logic              dir_up,
  output logic              step_n,
  output logic [POS_W-1:0]  wiper_pos
);

  function automatic int ns2cyc(input longint ns);
    longint c;
    c = (ns * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int C_SEL   = ns2cyc(T_SEL_SETUP_NS);
  localparam int C_DIR   = ns2cyc(T_DIR_SETUP_NS);
  localparam int C_SETUP = (C_SEL > C_DIR) ? C_SEL : C_DIR;
  localparam int C_LOW   = ns2cyc(T_LOW_NS);
  localparam int C_HIGH  = ns2cyc(T_HIGH_NS);
  localparam int C_TAIL  = ns2cyc(T_TAIL_NS);
  localparam int C_LAST  = (C_LOW > C_TAIL) ? C_LOW : C_TAIL;
  localparam int C_HOLD  = ns2cyc(T_DIR_HOLD_NS);
  localparam int C_RECOV = ns2cyc(T_RECOV_NS);
  localparam int C_M1    = (C_SETUP > C_LAST) ? C_SETUP : C_LAST;
  localparam int C_M2    = (C_HIGH > C_HOLD) ? C_HIGH : C_HOLD;
  localparam int C_MAXPH = (C_M1 > C_M2) ? C_M1 : C_M2;
  localparam int TW      = $clog2(C_MAXPH + 1);
  localparam int RW      = $clog2(C_RECOV + 1);
  localparam int POS_MAX = (1 << POS_W) - 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_TAIL, S_REL} st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [RW-1:0]     rec;
  logic [STEP_W-1:0] left;
  logic              commit_q;

  wire tmr_end   = (tmr == '0);
  wire last_step = (left == STEP_W'(1));

  function automatic logic [POS_W-1:0] bump(input logic [POS_W-1:0] p, input logic up);
    if (up)  return (p == POS_W'(POS_MAX)) ? p : p + 1'b1;
    else     return (p == '0) ? p : p - 1'b1;
  endfunction

  assign cmd_ready = (st == S_IDLE) && (rec == '0);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      rec       <= '0;
      left      <= '0;
      commit_q  <= 1'b0;
      sel_n     <= 1'b1;
      step_n    <= 1'b1;
      dir_up    <= 1'b0;
      done      <= 1'b0;
      wiper_pos <= POS_W'(RESET_POS);
    end else begin
      done <= 1'b0;
      if (rec != '0) rec <= rec - 1'b1;
      if (!tmr_end)  tmr <= tmr - 1'b1;
      case (st)
        S_IDLE: if (cmd_valid && cmd_ready) begin
          left     <= cmd_steps;
          commit_q <= cmd_commit;
          dir_up   <= cmd_up;
          if (cmd_steps == '0 && !cmd_commit) begin
            done <= 1'b1;
          end else begin
            sel_n <= 1'b0;
            st    <= S_SETUP;
            tmr   <= TW'(C_SETUP - 1);
          end
        end
        S_SETUP, S_HIGH: if (tmr_end) begin
          if (left == '0) begin
            st  <= S_TAIL;
            tmr <= TW'(C_TAIL - 1);
          end else begin
            st        <= S_LOW;
            step_n    <= 1'b0;
            left      <= left - 1'b1;
            wiper_pos <= bump(wiper_pos, dir_up);
            tmr       <= (last_step && !commit_q) ? TW'(C_LAST - 1) : TW'(C_LOW - 1);
          end
        end
        S_LOW: if (tmr_end) begin
          if (left == '0 && !commit_q) begin
            sel_n <= 1'b1;
            rec   <= RW'(C_RECOV);
            st    <= S_REL;
            tmr   <= TW'(C_HOLD - 1);
          end else begin
            step_n <= 1'b1;
            st     <= S_HIGH;
            tmr    <= TW'(C_HIGH - 1);
          end
        end
        S_TAIL: if (tmr_end) begin
          sel_n <= 1'b1;
          rec   <= RW'(C_RECOV);
          st    <= S_REL;
          tmr   <= TW'(C_HOLD - 1);
        end
        S_REL: if (tmr_end) begin
          step_n <= 1'b1;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW-1:0] lo_run;
  logic [RW-1:0] desel_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run    <= '0;
      desel_run <= '1;
    end else begin
      lo_run    <= step_n ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1'b1);
      desel_run <= !sel_n ? '0 : ((desel_run == '1) ? desel_run : desel_run + 1'b1);
    end
  end

  // R9
  pos_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_pos) |-> (!sel_n && $fell(step_n)));

  // R3
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !$past(sel_n)) |-> $stable(dir_up));

  // R4
  no_fall_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_n) |-> (!sel_n && !$past(sel_n)));

  // R4
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(step_n) && !sel_n) |-> (lo_run >= TW'(C_LOW)));

  // R8
  recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (desel_run >= RW'(C_RECOV)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/trim_seq_bench.sv
module trim_seq_bench;
  localparam int C_SETUP = 363;
  localparam int C_LOW   = 125;
  localparam int C_HIGH  = 125;
  localparam int C_TAIL  = 125;
  localparam int C_RECOV = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [5:0] cmd_steps = '0;
  logic       cmd_up = 1'b0;
  logic       cmd_commit = 1'b0;
  logic       busy, done, sel_n, dir_up, step_n;
  logic [4:0] wiper_pos;

  always #4 clk = ~clk;

  trim_seq #(.T_RECOV_NS(40_000)) u_trim_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_steps(cmd_steps), .cmd_up(cmd_up), .cmd_commit(cmd_commit),
    .busy(busy), .done(done), .sel_n(sel_n), .dir_up(dir_up),
    .step_n(step_n), .wiper_pos(wiper_pos));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {int steps; bit commit; int pos; bit sel; bit up;} exp_t;
  exp_t q[$];
  int   exp_pos = 0;

  int saw_sel = 0, setup_cyc = 0, falls = 0, lo_cnt = 0, hi_cnt = 0;
  int same_cnt = 0, hi_sel_cnt = 0, had_desel = 0, rise_step = 1, rise_same = 0;
  logic prev_sel = 1'b1, prev_step = 1'b1, prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sel && !sel_n) begin
        if (had_desel != 0) chk(hi_sel_cnt >= C_RECOV, "R8 recovery", hi_sel_cnt, C_RECOV);
        chk(busy && !cmd_ready, "R2/R10 busy while selected", int'(busy), 1);
        saw_sel = 1; setup_cyc = 0; falls = 0; lo_cnt = 0; hi_cnt = 0;
      end
      if (!prev_sel && sel_n) begin
        rise_step = int'(step_n); rise_same = same_cnt; hi_sel_cnt = 0; had_desel = 1;
      end
      if (prev_step && !step_n) begin
        if (sel_n) chk(0, "R4 step fell while deselected", 1, 0);
        falls++;
        if (falls == 1) chk(setup_cyc >= C_SETUP, "R3 setup before first step", setup_cyc, C_SETUP);
        else chk(hi_cnt >= C_HIGH, "R4 high width", hi_cnt, C_HIGH);
        lo_cnt = 0;
      end
      if (!prev_step && step_n) begin
        if (!sel_n) chk(lo_cnt >= C_LOW, "R4 low width", lo_cnt, C_LOW);
        hi_cnt = 0;
      end
      if (step_n) begin
        hi_cnt++;
        if (falls == 0 && !sel_n) setup_cyc++;
      end else lo_cnt++;
      if (step_n == prev_step) same_cnt++; else same_cnt = 1;
      if (sel_n) hi_sel_cnt++;
      if (prev_done) chk(!done, "R10 done single cycle", int'(done), 0);
      if (done) begin
        if (q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(saw_sel == int'(e.sel), "R7 select activity", saw_sel, int'(e.sel));
          chk(!busy, "R10 idle at done", int'(busy), 0);
          chk(int'(wiper_pos) == e.pos, "R9 shadow position", int'(wiper_pos), e.pos);
          if (e.sel) begin
            chk(falls == e.steps, "R4 step count", falls, e.steps);
            chk(dir_up == e.up, "R3 direction", int'(dir_up), int'(e.up));
            chk(rise_step == int'(e.commit), e.commit ? "R5 step high at release" : "R6 step low at release",
                rise_step, int'(e.commit));
            chk(rise_same >= C_TAIL, e.commit ? "R5 tail time" : "R6 last low hold", rise_same, C_TAIL);
            chk(step_n, "R6 step line restored", int'(step_n), 1);
          end
        end
        saw_sel = 0;
      end
    end
    prev_sel = sel_n; prev_step = step_n; prev_done = done;
  end

  task automatic send(input int steps, input bit up, input bit commit);
    exp_t e;
    bit sel;
    for (int k = 0; k < steps; k++) begin
      if (up && exp_pos < 31) exp_pos++;
      else if (!up && exp_pos > 0) exp_pos--;
    end
    sel = !(steps == 0 && !commit);
    e = '{steps, commit, exp_pos, sel, up};
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_steps = 6'(steps); cmd_up = up; cmd_commit = commit;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    if (sel) chk(!cmd_ready, "R2 ready low during recovery", int'(cmd_ready), 0);
    else     chk(cmd_ready, "R7 no recovery after empty command", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "R10 watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_n && step_n, "R1 lines idle", int'({sel_n, step_n}), 3);
    chk(!busy && !done, "R1 busy/done low", int'({busy, done}), 0);
    chk(cmd_ready, "R1 ready", int'(cmd_ready), 1);
    chk(wiper_pos == 5'd0, "R1 shadow reset", int'(wiper_pos), 0);
    send(3, 1'b1, 1'b1);
    send(2, 1'b0, 1'b0);
    send(40, 1'b1, 1'b1);
    send(0, 1'b0, 1'b0);
    send(5, 1'b0, 1'b0);
    send(63, 1'b0, 1'b1);
    send(0, 1'b1, 1'b1);
    send(1, 1'b0, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule